// File: doc/BRIEF.md
# Two-Level Interrupt Status Roll-Up

This block collects event interrupts from four identical datapath modules and presents them to a byte-wide microprocessor port as a two-level hierarchy. Each module owns one secondary status byte and one enable byte with the same bit layout. A read-only primary byte carries one bit per module. That bit is set whenever the module has at least one status bit set whose enable bit is also set. A single interrupt output is the OR of the primary bits.

The four event fields of each module are sticky. A one-cycle pulse sets the field, and it stays set until software writes a one to that bit position. The fifth field reports the module's performance monitor. It is not stored: it mirrors a level input, and writes to it have no effect. Software services an interrupt in three steps. It reads the primary byte to find the module. It reads that module's status byte to find the cause. It then writes ones to clear the causes it has handled.

Top module: `irq_rollup`

## Requirements
- R1: After reset, every status and enable register reads 0x00, the primary register reads 0x00 and `irqOut` is low, provided `evtPulse` and `monReady` are held low.
- R2: Module index m (0..3) has its status register at byte address 0x24+m and its enable register at 0x28+m. The primary register is at 0x2C. Accessing one module's register never reads or changes another module's registers.
- R3: Status bit b (0..3) of module m is set on the clock edge that samples `evtPulse[4*m+b]` high. It then stays set without any further pulse until it is cleared.
- R4: If an event pulse and a write that clears the same bit fall on the same clock edge, the bit is set after that edge.
- R5: A write to a status register clears every bit in 0..3 where the written byte has a 1 and leaves the bits written with 0 unchanged.
- R6: Status bit 4 of module m always equals `monReady[m]`. Writes to this bit have no effect.
- R7: An enable register stores bits 4:0 of the written byte and reads them back. Its bits 7:5 read as 0.
- R8: Primary bit m is 1 exactly when module m has some status bit in 0..4 that is 1 and whose enable bit is also 1. Primary bits 7:4 read 0. `irqOut` is the OR of primary bits 3:0.
- R9: Status bits 7:5 and any address outside 0x24..0x2C read as 0. Writes to the primary register or to unmapped addresses change no register.
- R10: `rdData` shows the addressed register's current contents in the same cycle while `rdEn` is high, and is 0x00 while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register accessed |
| wrData | input | 8 | Data written on a write cycle |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, combinational from the current state |
| evtPulse | input | 16 | Event pulses, bit 4*m+b is event b of module m |
| monReady | input | 4 | Performance-monitor ready level per module |
| irqOut | output | 1 | Summary interrupt request |

## Verification
The bench builds the block with its default constants: four modules, four sticky events each, and a byte-wide port. This configuration includes the lowest and highest module (A at 0x24, D at 0x27) and an enable pattern that masks some modules and unmasks others, so the primary byte is checked with mixed set and masked bits. Directed tests cover a clear that coincides with an event, a write to the monitor bit while its input is held high, a read with the strobe low, writes to the read-only and unmapped addresses, and a reset applied in the middle of the run.

// File: rtl/irq_rollup_pkg.sv
package irq_rollup_pkg;

  localparam int ModCnt   = 4;               // number of datapath modules
  localparam int EvtCnt   = 4;               // sticky pulse events per module
  localparam int ByteW    = 8;               // processor data width
  localparam int AddrW    = 8;               // processor address width
  localparam int StatW    = EvtCnt + 1;      // sticky events plus monitor bit
  localparam int IdxW     = $clog2(ModCnt);

  localparam logic [AddrW-1:0] StatBase = 8'h24;
  localparam logic [AddrW-1:0] EnBase   = 8'h28;
  localparam logic [AddrW-1:0] PrimAddr = 8'h2C;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STAT,
    RD_EN,
    RD_PRIM
  } rdSrc_e;

  // strobes from address decode to the register bank
  typedef struct packed {
    logic [ModCnt-1:0] statWr;
    logic [ModCnt-1:0] enWr;
    rdSrc_e            rdSrc;
    logic [IdxW-1:0]   rdIdx;
  } regStrb_t;

endpackage

// File: rtl/irq_rollup_ctrl.sv
module irq_rollup_ctrl
  import irq_rollup_pkg::*;
(
  input  logic [AddrW-1:0] addr,
  input  logic             wrEn,
  input  logic             rdEn,
  output regStrb_t         strb
);

  always_comb begin
    strb        = '0;
    strb.rdSrc  = RD_NONE;
    for (int m = 0; m < ModCnt; m++) begin
      if (addr == StatBase + AddrW'(m)) begin
        strb.statWr[m] = wrEn;
        if (rdEn) begin
          strb.rdSrc = RD_STAT;
          strb.rdIdx = IdxW'(m);
        end
      end
      if (addr == EnBase + AddrW'(m)) begin
        strb.enWr[m] = wrEn;
        if (rdEn) begin
          strb.rdSrc = RD_EN;
          strb.rdIdx = IdxW'(m);
        end
      end
    end
    // primary byte is read-only: no write strobe is ever generated for it
    if (rdEn && addr == PrimAddr) strb.rdSrc = RD_PRIM;
  end

endmodule

// File: rtl/irq_rollup_regs.sv
module irq_rollup_regs
  import irq_rollup_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrb_t                 strb,
  input  logic [ByteW-1:0]         wrData,
  input  logic [ModCnt*EvtCnt-1:0] evtPulse,
  input  logic [ModCnt-1:0]        monReady,
  output logic [ByteW-1:0]         rdData,
  output logic                     irqOut
);

  logic [ModCnt-1:0][EvtCnt-1:0] stick;
  logic [ModCnt-1:0][StatW-1:0]  enReg;
  logic [ModCnt-1:0][StatW-1:0]  statView;
  logic [ModCnt-1:0]             primary;

  // sticky events: set beats write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stick <= '0;
      enReg <= '0;
    end else begin
      for (int m = 0; m < ModCnt; m++) begin
        stick[m] <= (stick[m] & ~(strb.statWr[m] ? wrData[EvtCnt-1:0] : '0))
                    | evtPulse[m*EvtCnt +: EvtCnt];
        if (strb.enWr[m]) enReg[m] <= wrData[StatW-1:0];
      end
    end
  end

  for (genvar m = 0; m < ModCnt; m++) begin : g_mod
    assign statView[m] = {monReady[m], stick[m]};
    assign primary[m]  = |(statView[m] & enReg[m]);

    for (genvar b = 0; b < EvtCnt; b++) begin : g_bit
      // R3: a set bit holds unless a one is written to it
      a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
        (stick[m][b] && !(strb.statWr[m] && wrData[b])) |=> stick[m][b]);
      // R4: an event always leaves the bit set, clear or not
      a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
        evtPulse[m*EvtCnt+b] |=> stick[m][b]);
      // R5: a one written without a coincident event clears the bit
      a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
        (strb.statWr[m] && wrData[b] && !evtPulse[m*EvtCnt+b]) |=> !stick[m][b]);
    end

    // R7: enable register captures the written low bits
    a_r7_enable_load: assert property (@(posedge clk) disable iff (!rstN)
      strb.enWr[m] |=> enReg[m] == $past(wrData[StatW-1:0]));
  end

  assign irqOut = |primary;

  // R8: nothing enabled means no interrupt request
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irqOut);

  always_comb begin
    rdData = '0;
    unique case (strb.rdSrc)
      RD_STAT: rdData = ByteW'(statView[strb.rdIdx]);
      RD_EN:   rdData = ByteW'(enReg[strb.rdIdx]);
      RD_PRIM: rdData = ByteW'(primary);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_rollup.sv
module irq_rollup
  import irq_rollup_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [AddrW-1:0]         addr,
  input  logic [ByteW-1:0]         wrData,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output logic [ByteW-1:0]         rdData,
  input  logic [ModCnt*EvtCnt-1:0] evtPulse,
  input  logic [ModCnt-1:0]        monReady,
  output logic                     irqOut
);

  regStrb_t strb;

  irq_rollup_ctrl i_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  irq_rollup_regs i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .evtPulse (evtPulse),
    .monReady (monReady),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/test_irq_rollup.sv
module test_irq_rollup;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;   // address, or event bit index for OP_EV
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 30;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD, 8'h24, 8'h00, 8'h00, 4'd1},  // R1 status A
    '{OP_RD, 8'h28, 8'h00, 8'h00, 4'd1},  // R1 enable A
    '{OP_RD, 8'h2C, 8'h00, 8'h00, 4'd1},  // R1 primary
    '{OP_EV, 8'd0,  8'h00, 8'h00, 4'd3},
    '{OP_RD, 8'h24, 8'h00, 8'h01, 4'd3},  // R3 A capture set
    '{OP_RD, 8'h24, 8'h00, 8'h01, 4'd3},  // R3 still set
    '{OP_RD, 8'h2C, 8'h00, 8'h00, 4'd8},  // R8 masked
    '{OP_WR, 8'h28, 8'hFF, 8'h00, 4'd7},
    '{OP_RD, 8'h28, 8'h00, 8'h1F, 4'd7},  // R7 upper bits zero
    '{OP_RD, 8'h2C, 8'h00, 8'h01, 4'd8},  // R8 A pending
    '{OP_EV, 8'd13, 8'h00, 8'h00, 4'd3},
    '{OP_RD, 8'h27, 8'h00, 8'h02, 4'd3},  // R3 module D bit 1
    '{OP_RD, 8'h2C, 8'h00, 8'h01, 4'd8},  // R8 D masked
    '{OP_WR, 8'h2B, 8'h02, 8'h00, 4'd7},
    '{OP_RD, 8'h2C, 8'h00, 8'h09, 4'd8},  // R8 A and D
    '{OP_WR, 8'h24, 8'h00, 8'h00, 4'd5},
    '{OP_RD, 8'h24, 8'h00, 8'h01, 4'd5},  // R5 zero write keeps
    '{OP_WR, 8'h24, 8'hFF, 8'h00, 4'd5},
    '{OP_RD, 8'h24, 8'h00, 8'h00, 4'd5},  // R5 one clears
    '{OP_RD, 8'h2C, 8'h00, 8'h08, 4'd8},
    '{OP_WR, 8'h2C, 8'hFF, 8'h00, 4'd9},
    '{OP_RD, 8'h2C, 8'h00, 8'h08, 4'd9},  // R9 primary read-only
    '{OP_WR, 8'h30, 8'hFF, 8'h00, 4'd9},
    '{OP_RD, 8'h30, 8'h00, 8'h00, 4'd9},  // R9 unmapped
    '{OP_EV, 8'd6,  8'h00, 8'h00, 4'd2},
    '{OP_RD, 8'h25, 8'h00, 8'h04, 4'd2},  // R2 B only
    '{OP_RD, 8'h26, 8'h00, 8'h00, 4'd2},  // R2 C untouched
    '{OP_WR, 8'h2A, 8'hA5, 8'h00, 4'd7},
    '{OP_RD, 8'h2A, 8'h00, 8'h05, 4'd7},  // R7 low bits kept
    '{OP_RD, 8'h29, 8'h00, 8'h00, 4'd2}   // R2 B enable untouched
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [15:0] evtPulse = '0;
  logic [3:0]  monReady = '0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_rollup i_irq_rollup (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrData   (wrData),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .rdData   (rdData),
    .evtPulse (evtPulse),
    .monReady (monReady),
    .irqOut   (irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic doEvent(input int idx);
    @(negedge clk);
    evtPulse[idx] = 1'b1;
    @(negedge clk);
    evtPulse = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irq", {7'd0, irqOut}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR: doWrite(VECS[i].addr, VECS[i].data);
        OP_EV: doEvent(int'(VECS[i].addr));
        default: begin
          doRead(VECS[i].addr, rv);
          checks++;
          if (rv !== VECS[i].expv) begin
            failures++;
            $display("FAIL R%0d row %0d addr=%02h actual=%02h expected=%02h",
                     VECS[i].req, i, VECS[i].addr, rv, VECS[i].expv);
          end
        end
      endcase
    end

    // R8: D enabled with its bit 1 set drives the request
    @(negedge clk); #1;
    check("R8 irq set", {7'd0, irqOut}, 8'h01);
    doWrite(8'h27, 8'h02);
    @(negedge clk); #1;
    check("R8 irq clear", {7'd0, irqOut}, 8'h00);

    // R6: monitor bit mirrors the level and ignores writes
    @(negedge clk); monReady[2] = 1'b1;
    doRead(8'h26, rv); check("R6 follow", rv, 8'h10);
    doWrite(8'h26, 8'h10);
    doRead(8'h26, rv); check("R6 write ignored", rv, 8'h10);
    check("R8 monitor masked", {7'd0, irqOut}, 8'h00);
    doWrite(8'h2A, 8'h10);
    doRead(8'h2C, rv); check("R8 monitor primary", rv, 8'h04);

    // R10: no strobe, no data
    @(negedge clk); addr = 8'h26; #1;
    check("R10 rdEn low", rdData, 8'h00);

    @(negedge clk); monReady[2] = 1'b0;
    doRead(8'h26, rv); check("R6 level drop", rv, 8'h00);
    check("R8 monitor gone", {7'd0, irqOut}, 8'h00);

    // R4: event and clear on the same edge
    @(negedge clk);
    addr = 8'h24; wrData = 8'h01; wrEn = 1'b1; evtPulse[0] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; evtPulse = '0;
    doRead(8'h24, rv); check("R4 event wins", rv, 8'h01);
    check("R8 irq from A", {7'd0, irqOut}, 8'h01);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doRead(8'h24, rv); check("R1 status after reset", rv, 8'h00);
    doRead(8'h28, rv); check("R1 enable after reset", rv, 8'h00);
    check("R1 irq after reset", {7'd0, irqOut}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule